// File: doc/BRIEF.md
# Dual-Channel Serial Register File with Pointer Access

This block is the byte-wide register front end of a two-channel serial controller. A small bus window is split into two channels, each offering a command location and a data location. Each channel holds sixteen write registers and sixteen read registers. They are reached through a two-step pointer protocol. The first command write picks a register number. The second command write stores a value there. A command read returns the selected read register. After either finishing access, the pointer drops back to register 0.

The data location is the byte path. A write sends one byte out on a one-cycle transmit strobe. When the channel's loopback control is set, that byte is also placed in the channel's own receive FIFO. A read takes one byte from the receive FIFO. The FIFO is also filled from an external receive input, one port per channel. Interrupt-pending bits come in from a separate pending-logic block and can be read back.

Two bus quirks are supported. Two alias addresses reach the first channel's command and data locations. A word-shifted access mode carries the byte in bits 15:8 instead of bits 7:0.

Top module: `twin_serial_regfile`

## Requirements
- R1: The channel is address bit 3. Within a channel, offset 1 (address bits 2:0) is the command location and offset 5 is the data location. An access to any other offset, outside the shifted mode, changes nothing and reads 0.
- R2: If no register number is pending, a command write loads the pointer with data bits 3:0 and marks a number as pending. If a number is pending, the write stores the byte in that write register, returns the pointer to 0 and clears the pending mark.
- R3: A command read returns the read register chosen by the pointer. It then returns the pointer to 0 and clears the pending mark.
- R4: When the offset is 0 or 4 and data bits 7:0 are zero, the access is handled as offset 1 or 5 with the byte taken from bits 15:8. Read data then appears in bits 15:8. A read drives the write-data lines, and this same test applies to them.
- R5: Address 0x0F reaches the command location of channel 0, and address 0x1F reaches the data location of channel 0.
- R6: Read registers 12 and 13 always return the current contents of write registers 12 and 13 of the same channel.
- R7: When bit 4 of write register 14 is set, a data write also pushes its byte into the same channel's receive FIFO.
- R8: Read register 0 has bit 2 (transmit empty) always at 1, and bit 0 at 1 exactly when the channel's FIFO holds data. All its other bits are 0. Read register 1 always reads 0.
- R9: A data read returns the oldest FIFO byte and removes it. On an empty FIFO it returns 0 and leaves the FIFO unchanged.
- R10: Each FIFO holds 16 bytes. A push into a full FIFO drops the byte and sets that channel's sticky overrun output. When a loopback push and an external push hit the same channel in the same cycle, the loopback byte is kept, the external byte is dropped, and overrun is set.
- R11: Reset clears all write registers, both pointers, both FIFOs, the overrun flags and the transmit strobe.
- R12: A data write raises the transmit strobe for one cycle after the access. The strobe carries the byte and the channel number.
- R13: Read register 3 of channel 0 returns the 8-bit pending input. Read register 3 of channel 1 reads 0.

Read data is registered: it appears on `bus_rdata` in the cycle after the read access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per asserted cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address within the window |
| bus_wdata | input | 16 | Write data (also tested for the shifted mode on reads) |
| bus_rdata | output | 16 | Registered read data |
| rx_push | input | 2 | External receive strobe, one bit per channel |
| rx_data | input | 16 | External receive bytes, channel c in bits 8c+7:8c |
| pend_in | input | 8 | Interrupt-pending bits from the pending logic |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Transmitted byte |
| tx_chan | output | 1 | Channel of the transmitted byte |
| rx_overrun | output | 2 | Sticky overrun flag per channel |

## Verification
The bench checks that the pointer returns to register 0 after every finished access. A design that keeps the pointer would answer a bare command read with a stale register instead of read register 0. The shifted mode is tested on reads and writes, together with a write of nonzero low data to offset 2. A decoder that skips the low-byte test, or that treats any offset as a command, would then move the pointer by mistake. The receive FIFO is filled past 16 entries, read until empty and read once more. This exposes dropped or overwritten data, a non-sticky overrun flag and a pop on empty that corrupts the queue. A loopback write that collides with an external push checks which byte is kept. The alias addresses are checked for landing on channel 0.

// File: rtl/serial_regs_pkg.sv
package serial_regs_pkg;

   localparam int unsigned BYTE_W      = 8;
   localparam int unsigned OFF_CMD     = 1;
   localparam int unsigned OFF_DATA    = 5;
   localparam int unsigned RR0_RXAVAIL = 0;
   localparam int unsigned RR0_TXEMPTY = 2;
   localparam int unsigned LOOP_BIT    = 4;
   localparam int unsigned REG_MIRROR0 = 12;
   localparam int unsigned REG_MIRROR1 = 13;
   localparam int unsigned REG_PEND    = 3;
   localparam int unsigned REG_ERRS    = 1;
   localparam int unsigned REG_LOOP    = 14;

   typedef enum logic [1:0] {
      LOC_NONE = 2'd0,
      LOC_CMD  = 2'd1,
      LOC_DATA = 2'd2
   } loc_e;

endpackage

// File: rtl/serial_addr_decode.sv
module serial_addr_decode
   import serial_regs_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned BUS_W  = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   output logic              chan,
   output loc_e              loc,
   output logic [BYTE_W-1:0] byte_in,
   output logic              shifted
);

   localparam logic [ADDR_W-1:0] ALIAS_CMD  = ADDR_W'(8'h0F);
   localparam logic [ADDR_W-1:0] ALIAS_DATA = ADDR_W'(8'h1F);

   if (ADDR_W < 5) begin : g_bad_addr
      $error("serial_addr_decode: ADDR_W must be at least 5");
   end
   if (BUS_W < 2 * BYTE_W) begin : g_bad_bus
      $error("serial_addr_decode: BUS_W must hold two bytes");
   end

   logic [2:0] off_raw;
   logic [2:0] off_eff;
   logic       low_zero;

   always_comb begin
      chan    = addr[3];
      off_raw = addr[2:0];
      if (addr == ALIAS_CMD) begin
         chan    = 1'b0;
         off_raw = 3'(OFF_CMD);
      end else if (addr == ALIAS_DATA) begin
         chan    = 1'b0;
         off_raw = 3'(OFF_DATA);
      end
      low_zero = (wdata[BYTE_W-1:0] == '0);
      shifted  = low_zero && (off_raw == 3'd0 || off_raw == 3'd4);
      off_eff  = shifted ? off_raw + 3'd1 : off_raw;
      byte_in  = shifted ? wdata[2*BYTE_W-1:BYTE_W] : wdata[BYTE_W-1:0];
      if (off_eff == 3'(OFF_CMD))       loc = LOC_CMD;
      else if (off_eff == 3'(OFF_DATA)) loc = LOC_DATA;
      else                              loc = LOC_NONE;
   end

endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         drop,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         not_empty,
   output logic         overrun
);

   localparam int unsigned AW = $clog2(DEPTH);
   localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("serial_rx_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          full, do_pop, do_push;

   assign full      = (cnt == CNT_FULL);
   assign not_empty = (cnt != '0);
   assign head      = not_empty ? mem[rp] : '0;
   assign do_pop    = pop && not_empty;
   assign do_push   = push && (!full || do_pop);

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp      <= '0;
         rp      <= '0;
         cnt     <= '0;
         overrun <= 1'b0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
         if ((push && !do_push) || drop) overrun <= 1'b1;
      end
   end

   assert_no_overflow_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_FULL);
   assert_overrun_sticky_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
   assert_empty_pop_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !not_empty && !push) |=> !not_empty);

endmodule

// File: rtl/serial_chan_regs.sv
module serial_chan_regs
   import serial_regs_pkg::*;
#(
   parameter int unsigned NREG       = 16,
   parameter bit          IS_PRIMARY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic              cmd_rd,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic              rx_avail,
   input  logic [BYTE_W-1:0] pend_bits,
   output logic [BYTE_W-1:0] rd_byte,
   output logic              loop_en
);

   localparam int unsigned PW = $clog2(NREG);

   if (NREG != 16) begin : g_bad_nreg
      $error("serial_chan_regs: NREG must be 16");
   end

   logic [BYTE_W-1:0] wreg [NREG];
   logic [PW-1:0]     ptr;
   logic              sel_pend;
   logic [BYTE_W-1:0] pend_view;

   if (IS_PRIMARY) begin : g_pend_on
      assign pend_view = pend_bits;
   end else begin : g_pend_off
      assign pend_view = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr      <= '0;
         sel_pend <= 1'b0;
         for (int i = 0; i < NREG; i++) wreg[i] <= '0;
      end else if (cmd_wr) begin
         if (!sel_pend) begin
            ptr      <= wr_byte[PW-1:0];
            sel_pend <= 1'b1;
         end else begin
            wreg[ptr] <= wr_byte;
            ptr       <= '0;
            sel_pend  <= 1'b0;
         end
      end else if (cmd_rd) begin
         ptr      <= '0;
         sel_pend <= 1'b0;
      end
   end

   always_comb begin
      rd_byte = '0;
      case (ptr)
         PW'(0): begin
            rd_byte[RR0_TXEMPTY] = 1'b1;
            rd_byte[RR0_RXAVAIL] = rx_avail;
         end
         PW'(REG_ERRS):    rd_byte = '0;
         PW'(REG_PEND):    rd_byte = pend_view;
         PW'(REG_MIRROR0): rd_byte = wreg[REG_MIRROR0];
         PW'(REG_MIRROR1): rd_byte = wreg[REG_MIRROR1];
         default:          rd_byte = '0;
      endcase
   end

   assign loop_en = wreg[REG_LOOP][LOOP_BIT];

   assert_store_clears_ptr_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && sel_pend) |=> (!sel_pend && ptr == '0));
   assert_select_pends_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !sel_pend) |=> sel_pend);
   assert_read_clears_ptr_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_rd && !cmd_wr) |=> (!sel_pend && ptr == '0));

endmodule

// File: rtl/twin_serial_regfile.sv
module twin_serial_regfile
   import serial_regs_pkg::*;
#(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned BUS_W      = 16,
   parameter int unsigned NCH        = 2,
   parameter int unsigned NREG       = 16,
   parameter int unsigned FIFO_DEPTH = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   input  logic [NCH-1:0]       rx_push,
   input  logic [NCH*BYTE_W-1:0] rx_data,
   input  logic [BYTE_W-1:0]    pend_in,
   output logic                 tx_valid,
   output logic [BYTE_W-1:0]    tx_data,
   output logic                 tx_chan,
   output logic [NCH-1:0]       rx_overrun
);

   if (NCH != 2) begin : g_bad_nch
      $error("twin_serial_regfile: NCH must be 2 (one address bit picks the channel)");
   end

   logic              d_chan;
   loc_e              d_loc;
   logic [BYTE_W-1:0] d_byte;
   logic              d_shift;

   serial_addr_decode #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_dec (
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .chan    (d_chan),
      .loc     (d_loc),
      .byte_in (d_byte),
      .shifted (d_shift)
   );

   logic [NCH-1:0]    cmd_wr, cmd_rd, dat_wr, dat_rd, loop_en, avail;
   logic [BYTE_W-1:0] reg_rd [NCH];
   logic [BYTE_W-1:0] fifo_hd [NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic hit, loop_push, ext_push, f_push;
      logic [BYTE_W-1:0] f_data;

      assign hit       = bus_sel && (d_chan == 1'(c));
      assign cmd_wr[c] = hit &&  bus_wr && (d_loc == LOC_CMD);
      assign cmd_rd[c] = hit && !bus_wr && (d_loc == LOC_CMD);
      assign dat_wr[c] = hit &&  bus_wr && (d_loc == LOC_DATA);
      assign dat_rd[c] = hit && !bus_wr && (d_loc == LOC_DATA);

      assign loop_push = dat_wr[c] && loop_en[c];
      assign ext_push  = rx_push[c];
      assign f_push    = loop_push || ext_push;
      assign f_data    = loop_push ? d_byte : rx_data[c*BYTE_W +: BYTE_W];

      serial_chan_regs #(.NREG(NREG), .IS_PRIMARY(c == 0)) u_regs (
         .clk       (clk),
         .rst_n     (rst_n),
         .cmd_wr    (cmd_wr[c]),
         .cmd_rd    (cmd_rd[c]),
         .wr_byte   (d_byte),
         .rx_avail  (avail[c]),
         .pend_bits (pend_in),
         .rd_byte   (reg_rd[c]),
         .loop_en   (loop_en[c])
      );

      serial_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
         .clk       (clk),
         .rst_n     (rst_n),
         .push      (f_push),
         .push_data (f_data),
         .drop      (loop_push && ext_push),
         .pop       (dat_rd[c]),
         .head      (fifo_hd[c]),
         .not_empty (avail[c]),
         .overrun   (rx_overrun[c])
      );
   end

   logic [BYTE_W-1:0] rd_sel;

   always_comb begin
      case (d_loc)
         LOC_CMD:  rd_sel = reg_rd[d_chan];
         LOC_DATA: rd_sel = fifo_hd[d_chan];
         default:  rd_sel = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         tx_valid  <= 1'b0;
         tx_data   <= '0;
         tx_chan   <= 1'b0;
      end else begin
         if (bus_sel && !bus_wr)
            bus_rdata <= d_shift ? BUS_W'({rd_sel, {BYTE_W{1'b0}}}) : BUS_W'(rd_sel);
         tx_valid <= |dat_wr;
         if (|dat_wr) begin
            tx_data <= d_byte;
            tx_chan <= d_chan;
         end
      end
   end

   assert_tx_strobe_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && d_loc == LOC_DATA) |=> (tx_valid && tx_data == $past(d_byte)));
   assert_tx_pulse_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr && d_loc == LOC_DATA) |=> !tx_valid);
   assert_one_target_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_wr, cmd_rd, dat_wr, dat_rd}));

endmodule

// File: tb/test_twin_serial_regfile.sv
module test_twin_serial_regfile;

   localparam time CLK_P = 4ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [1:0]  rx_push = '0;
   logic [15:0] rx_data = '0;
   logic [7:0]  pend_in = '0;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_chan;
   logic [1:0]  rx_overrun;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;
   bit want_tx  = 1'b0;

   logic [15:0] exp_rd_q [$];
   string       tag_rd_q [$];
   logic [8:0]  exp_tx_q [$];
   string       tag_tx_q [$];

   always #(CLK_P/2) clk = ~clk;

   twin_serial_regfile i_twin_serial_regfile (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_push(rx_push), .rx_data(rx_data), .pend_in(pend_in),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_chan(tx_chan),
      .rx_overrun(rx_overrun)
   );

   task automatic check(input bit ok, input string tag, input logic [15:0] act,
                        input logic [15:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // monitor: compares results as the design produces them
   always @(posedge clk) begin
      if (rst_n && bus_sel) begin
         #1;
         if (!bus_wr && exp_rd_q.size() > 0) begin
            automatic logic [15:0] e = exp_rd_q.pop_front();
            automatic string t = tag_rd_q.pop_front();
            check(bus_rdata === e, t, bus_rdata, e);
         end else if (bus_wr && want_tx && exp_tx_q.size() > 0) begin
            automatic logic [8:0] e = exp_tx_q.pop_front();
            automatic string t = tag_tx_q.pop_front();
            check(tx_valid === 1'b1 && {tx_chan, tx_data} === e, t,
                  {6'd0, tx_valid, tx_chan, tx_data}, {7'd1, e});
         end
      end
   end

   task automatic bus_op(input logic [4:0] a, input bit w, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      want_tx = 1'b0;
      bus_op(a, 1'b1, d);
   endtask

   task automatic rd(input logic [4:0] a, input logic [15:0] d, input logic [15:0] e,
                     input string t);
      exp_rd_q.push_back(e);
      tag_rd_q.push_back(t);
      bus_op(a, 1'b0, d);
   endtask

   task automatic tx(input logic [4:0] a, input logic [15:0] d, input logic [7:0] eb,
                     input bit ec, input string t);
      exp_tx_q.push_back({ec, eb});
      tag_tx_q.push_back(t);
      want_tx = 1'b1;
      bus_op(a, 1'b1, d);
      want_tx = 1'b0;
   endtask

   task automatic ext_push(input int ch, input logic [7:0] b);
      @(negedge clk);
      rx_push = 2'b00; rx_push[ch] = 1'b1;
      rx_data[ch*8 +: 8] = b;
      @(negedge clk);
      rx_push = 2'b00;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_fails++;
         n_checks++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check(rx_overrun === 2'b00, "R11 overrun after reset", 16'(rx_overrun), 16'h0);
      check(tx_valid === 1'b0, "R11 tx idle after reset", 16'(tx_valid), 16'h0);
      check(bus_rdata === 16'h0, "R11 rdata after reset", bus_rdata, 16'h0);
      rst_n = 1'b1;

      rd(5'h01, 16'h0, 16'h0004, "R8 R11 ch0 RR0 idle");
      // R2 R6 store WR12 on ch0
      wr(5'h01, 16'h000C); wr(5'h01, 16'h005A);
      wr(5'h01, 16'h000C);
      rd(5'h01, 16'h0, 16'h005A, "R6 R2 ch0 RR12");
      rd(5'h01, 16'h0, 16'h0004, "R3 pointer back to 0");
      // R1 channel separation
      wr(5'h09, 16'h000D); wr(5'h09, 16'h003C); wr(5'h09, 16'h000D);
      rd(5'h09, 16'h0, 16'h003C, "R6 ch1 RR13");
      wr(5'h01, 16'h000D);
      rd(5'h01, 16'h0, 16'h0000, "R1 ch0 RR13 untouched");
      // R8 RR1 reads 0
      wr(5'h01, 16'h0001); wr(5'h01, 16'h00FF); wr(5'h01, 16'h0001);
      rd(5'h01, 16'h0, 16'h0000, "R8 RR1 zero");
      // R12 transmit, no loopback
      tx(5'h05, 16'h0041, 8'h41, 1'b0, "R12 ch0 tx");
      rd(5'h01, 16'h0, 16'h0004, "R7 no loopback push");
      // R7 loopback
      wr(5'h01, 16'h000E); wr(5'h01, 16'h0010);
      tx(5'h05, 16'h0042, 8'h42, 1'b0, "R12 loop tx1");
      tx(5'h05, 16'h0043, 8'h43, 1'b0, "R12 loop tx2");
      rd(5'h01, 16'h0, 16'h0005, "R8 R7 rx avail");
      rd(5'h05, 16'h0, 16'h0042, "R9 R7 pop first");
      rd(5'h05, 16'h0, 16'h0043, "R9 pop second");
      rd(5'h05, 16'h0, 16'h0000, "R9 empty read");
      rd(5'h01, 16'h0, 16'h0004, "R8 empty again");
      // external receive, ch1
      ext_push(1, 8'h99);
      rd(5'h09, 16'h0, 16'h0005, "R8 ch1 avail");
      rd(5'h0D, 16'h0, 16'h0099, "R9 ch1 pop");
      rd(5'h0D, 16'h0, 16'h0000, "R9 ch1 empty");
      tx(5'h0D, 16'h002B, 8'h2B, 1'b1, "R12 ch1 tx chan");
      rd(5'h0D, 16'h0, 16'h0000, "R7 ch1 no loopback");
      // R5 aliases
      wr(5'h0F, 16'h000C);
      rd(5'h0F, 16'h0, 16'h005A, "R5 alias cmd");
      tx(5'h1F, 16'h0077, 8'h77, 1'b0, "R5 alias data tx");
      rd(5'h1F, 16'h0, 16'h0077, "R5 alias data rd");
      // R4 word-shifted mode
      wr(5'h00, 16'h0C00);
      rd(5'h00, 16'h0, 16'h5A00, "R4 shifted cmd read");
      tx(5'h04, 16'h6600, 8'h66, 1'b0, "R4 shifted data write");
      rd(5'h04, 16'h0, 16'h6600, "R4 shifted data read");
      wr(5'h00, 16'h000C);
      rd(5'h01, 16'h0, 16'h0004, "R4 nonzero low byte ignored");
      // R1 other offsets
      wr(5'h02, 16'h000C);
      rd(5'h01, 16'h0, 16'h0004, "R1 offset 2 write ignored");
      rd(5'h02, 16'h0, 16'h0000, "R1 offset 2 reads 0");
      // R13 pending
      pend_in = 8'hA5;
      wr(5'h01, 16'h0003);
      rd(5'h01, 16'h0, 16'h00A5, "R13 ch0 RR3");
      wr(5'h09, 16'h0003);
      rd(5'h09, 16'h0, 16'h0000, "R13 ch1 RR3");
      // R10 overflow ch1
      @(negedge clk);
      for (int i = 0; i < 17; i++) begin
         rx_push = 2'b10;
         rx_data[15:8] = (i == 16) ? 8'hEE : 8'(i + 16);
         @(negedge clk);
      end
      rx_push = 2'b00;
      check(rx_overrun === 2'b10, "R10 overrun ch1 only", 16'(rx_overrun), 16'h2);
      for (int i = 0; i < 16; i++)
         rd(5'h0D, 16'h0, 16'(i + 16), "R10 fifo order");
      rd(5'h0D, 16'h0, 16'h0000, "R10 dropped byte absent");
      check(rx_overrun === 2'b10, "R10 overrun sticky", 16'(rx_overrun), 16'h2);
      // R10 loopback vs external collision on ch0
      exp_tx_q.push_back({1'b0, 8'h31});
      tag_tx_q.push_back("R12 collision tx");
      @(negedge clk);
      want_tx = 1'b1;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h05; bus_wdata = 16'h0031;
      rx_push = 2'b01; rx_data[7:0] = 8'hBB;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; rx_push = 2'b00; want_tx = 1'b0;
      check(rx_overrun === 2'b11, "R10 collision overrun", 16'(rx_overrun), 16'h3);
      rd(5'h05, 16'h0, 16'h0031, "R10 loopback byte kept");
      rd(5'h05, 16'h0, 16'h0000, "R10 external byte dropped");
      // R11 reset mid-run
      ext_push(1, 8'h12);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(rx_overrun === 2'b00, "R11 overrun cleared", 16'(rx_overrun), 16'h0);
      rst_n = 1'b1;
      wr(5'h01, 16'h000C);
      rd(5'h01, 16'h0, 16'h0000, "R11 WR12 cleared");
      rd(5'h09, 16'h0, 16'h0004, "R11 ch1 fifo cleared");
      rd(5'h0D, 16'h0, 16'h0000, "R11 ch1 pop empty");
      repeat (3) @(negedge clk);
      check(exp_rd_q.size() == 0 && exp_tx_q.size() == 0, "R12 all results seen",
            16'(exp_rd_q.size() + exp_tx_q.size()), 16'h0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule